// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block receives asynchronous serial characters on a single line and hands them to a host through a small register interface. An external prescaler supplies a one-cycle oversampling tick. The receiver counts these ticks to find bit centres. Each bit takes 16 ticks in normal mode and 8 ticks in fast mode. The value of each bit is the majority of three samples taken around its centre.

A completed character first sits in a hold stage, which models a shift register with a finished character in it. From there it moves into a two-entry receive buffer. Every buffer entry carries its own stop-bit error, parity error and lost-data flags. The status register always shows the flags of the entry at the head of the buffer, so the host reads a character's flags before it pops that character. In address-filter mode, the receiver drops every frame whose ninth bit is clear before it reaches the hold stage.

The status register also reflects two transmit-side conditions that arrive as inputs: a transmit-done pulse and a transmit-buffer-empty level. The host controls two bits of the register directly.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `csr_status_o` reads 0x20. The transmit-empty bit is bit 5, and every other bit is 0. `rx_data_o` reads 0.
- R2: Status layout: bit 7 is 1 while the buffer holds at least one character. Bit 4 is the stop error, bit 3 the lost-data flag and bit 2 the parity error. Each of these three bits belongs to the head entry, and all three read 0 when the buffer is empty.
- R3: A frame is a low start bit, then data least significant bit first, then an optional parity bit, then one stop bit. There are 8 data bits, or 9 when `nine_bit_i` is 1. `rx_data_o` shows the head character with its unused upper bits at 0.
- R4: With status bit 1 at 0, one bit lasts 16 ticks of `os_tick_i`. With status bit 1 at 1, one bit lasts 8 ticks.
- R5: A character whose stop bit samples as 0 is stored with its stop-error flag set. A character whose stop bit samples as 1 has the flag clear.
- R6: With `par_en_i` at 1, the parity bit must equal the XOR of the data bits, inverted when `par_odd_i` is 1. A mismatch sets the parity-error flag. With `par_en_i` at 0, no parity bit is received and the flag is always 0.
- R7: Suppose both buffer entries are full and a finished character waits in the hold stage when a new start bit is accepted. That waiting character is lost, and the next character stored afterwards carries the lost-data flag.
- R8: Pulsing `rx_pop_i` removes the head entry together with its flags. The next entry becomes the head, and a waiting character moves into the freed slot.
- R9: With status bit 0 at 1, any frame whose ninth data bit is 0 is dropped. A frame is also dropped when `nine_bit_i` is 0. A dropped frame never appears in the buffer.
- R10: A write to the status register loads bits 1 and 0. Writing 1 to bit 6 clears it. Bits 7, 5, 4, 3 and 2 ignore the write.
- R11: A `tx_done_i` pulse sets bit 6, and it wins over a clear in the same cycle. Bit 5 follows `tx_empty_i` one clock later.
- R12: A low level that has returned high by the middle of the start bit does not begin a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick_i | input | 1 | Oversampling tick from the prescaler |
| rxd_i | input | 1 | Serial input line, idle high |
| nine_bit_i | input | 1 | Selects 9 data bits |
| par_en_i | input | 1 | Enables the parity bit |
| par_odd_i | input | 1 | Selects odd parity |
| csr_wr_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 8 | Status register write data |
| csr_status_o | output | 8 | Status register read value |
| rx_pop_i | input | 1 | Reads and removes the head character |
| rx_data_o | output | 9 | Head character |
| tx_done_i | input | 1 | Transmit-complete pulse |
| tx_empty_i | input | 1 | Transmit buffer empty level |

## Verification
The bench builds the block with its default values: a buffer depth of 2 and oversampling divisors of 16 and 8. With these values, four back-to-back characters are enough to fill both entries and the hold stage, which triggers the lost-data case. The bench generates one tick every two clocks, so a full-speed frame stays short enough to run both divisor settings, both parity senses, bad stop bits and address filtering in one run.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int DATA_W = 9;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              ovr;
    logic              pe;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
#(
  parameter int OS_NORMAL = 16,
  parameter int OS_FAST   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              fast_i,
  input  logic              nine_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              start_ok_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int CNT_W = $clog2(OS_NORMAL);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OS_NORMAL - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OS_FAST - 1);
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OS_NORMAL / 2);
  localparam logic [CNT_W-1:0] MID_F  = CNT_W'(OS_FAST / 2);

  logic              sync1_q, sync2_q;
  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [3:0]        bit_q, bit_n;
  logic [DATA_W-1:0] shift_q, shift_n;
  logic [1:0]        smp_q, smp_n;
  logic              par_q, par_n;
  logic              pe_q, pe_n;
  logic              maj;
  logic [CNT_W-1:0]  last_c, mid_c;
  logic [3:0]        last_bit;

  // Two-flop synchronizer on the serial line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      sync2_q <= sync1_q;
    end
  end

  assign last_c   = fast_i ? LAST_F : LAST_N;
  assign mid_c    = fast_i ? MID_F : MID_N;
  assign last_bit = nine_i ? 4'd8 : 4'd7;
  assign maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & sync2_q) | (smp_q[1] & sync2_q);

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    bit_n      = bit_q;
    shift_n    = shift_q;
    smp_n      = smp_q;
    par_n      = par_q;
    pe_n       = pe_q;
    start_ok_o = 1'b0;
    done_o     = 1'b0;
    fe_o       = 1'b0;
    if (tick_i) begin
      if (state_q == S_IDLE) begin
        if (!sync2_q) begin
          state_n = S_START;
          cnt_n   = '0;
        end
      end else begin
        cnt_n = (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
        if (cnt_q == mid_c - 1'b1) smp_n[0] = sync2_q;
        if (cnt_q == mid_c)        smp_n[1] = sync2_q;
        if (cnt_q == mid_c + 1'b1) begin
          unique case (state_q)
            S_START: begin
              if (maj) begin
                state_n = S_IDLE;
              end else begin
                start_ok_o = 1'b1;
                par_n      = par_odd_i;
                pe_n       = 1'b0;
                bit_n      = '0;
                shift_n    = '0;
              end
            end
            S_DATA: begin
              shift_n = {maj, shift_q[DATA_W-1:1]};
              par_n   = par_q ^ maj;
            end
            S_PAR:  pe_n = par_en_i & (par_q ^ maj);
            S_STOP: begin
              done_o  = 1'b1;
              fe_o    = ~maj;
              state_n = S_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == last_c) begin
          unique case (state_q)
            S_START: state_n = S_DATA;
            S_DATA: begin
              if (bit_q == last_bit) state_n = par_en_i ? S_PAR : S_STOP;
              else                   bit_n   = bit_q + 1'b1;
            end
            S_PAR:   state_n = S_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  assign data_o = nine_i ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
  assign pe_o   = pe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      smp_q   <= '1;
      par_q   <= 1'b0;
      pe_q    <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      shift_q <= shift_n;
      smp_q   <= smp_n;
      par_q   <= par_n;
      pe_q    <= pe_n;
    end
  end
endmodule

// File: rtl/urx_buffer.sv
module urx_buffer
  import urx_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              filt_i,
  input  logic              nine_i,
  input  logic              pop_i,
  output rx_entry_t         head_o,
  output logic [CW-1:0]     cnt_o,
  output logic              hold_v_o,
  output logic              ovr_pend_o
);
  rx_entry_t        hold_q, hold_n;
  logic             hold_v_q, hold_v_n;
  logic             pend_q, pend_n;
  logic [CW-1:0]    cnt_q, cnt_n, widx;
  logic             accept, pop, room, move, drop;
  rx_entry_t        slot_q [DEPTH];

  assign accept = done_i & ~(filt_i & ~(nine_i & data_i[DATA_W-1]));
  assign pop    = pop_i & (cnt_q != '0);
  assign room   = (cnt_q < CW'(DEPTH)) | pop;
  assign move   = hold_v_q & room;
  assign drop   = start_ok_i & hold_v_q & ~room;
  assign widx   = cnt_q - CW'(pop);

  always_comb begin
    hold_n   = hold_q;
    hold_v_n = hold_v_q;
    pend_n   = pend_q;
    if (accept) begin
      hold_n   = '{data: data_i, fe: fe_i, ovr: pend_q, pe: pe_i};
      hold_v_n = 1'b1;
      pend_n   = 1'b0;
    end else if (move || drop) begin
      hold_v_n = 1'b0;
    end
    if (drop) pend_n = 1'b1;
    cnt_n = cnt_q + CW'(move) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      hold_q   <= hold_n;
      hold_v_q <= hold_v_n;
      pend_q   <= pend_n;
      cnt_q    <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_entry_t nxt;
    logic      en;
    logic      wr_here;
    assign wr_here = move && (widx == CW'(i));
    assign en      = pop | wr_here;
    if (i + 1 < DEPTH) begin : g_mid
      assign nxt = wr_here ? hold_q : slot_q[i+1];
    end else begin : g_top
      assign nxt = wr_here ? hold_q : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= '0;
      else if (en) slot_q[i] <= nxt;
    end
  end

  assign head_o     = slot_q[0];
  assign cnt_o      = cnt_q;
  assign hold_v_o   = hold_v_q;
  assign ovr_pend_o = pend_q;
endmodule

// File: rtl/urx_csr.sv
module urx_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       tx_done_i,
  input  logic       tx_empty_i,
  input  logic       nonempty_i,
  input  logic       fe_i,
  input  logic       ovr_i,
  input  logic       pe_i,
  output logic [7:0] status_o,
  output logic       fast_o,
  output logic       filt_o
);
  logic txc_q, txc_n;
  logic txe_q;
  logic fast_q, fast_n;
  logic filt_q, filt_n;

  always_comb begin
    txc_n  = txc_q;
    fast_n = fast_q;
    filt_n = filt_q;
    if (wr_i) begin
      if (wdata_i[6]) txc_n = 1'b0;
      fast_n = wdata_i[1];
      filt_n = wdata_i[0];
    end
    if (tx_done_i) txc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q  <= 1'b0;
      txe_q  <= 1'b1;
      fast_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      txc_q  <= txc_n;
      txe_q  <= tx_empty_i;
      fast_q <= fast_n;
      filt_q <= filt_n;
    end
  end

  assign status_o = {nonempty_i, txc_q, txe_q, nonempty_i & fe_i,
                     nonempty_i & ovr_i, nonempty_i & pe_i, fast_q, filt_q};
  assign fast_o   = fast_q;
  assign filt_o   = filt_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import urx_pkg::*;
#(
  parameter int DEPTH     = 2,
  parameter int OS_NORMAL = 16,
  parameter int OS_FAST   = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              csr_wr_i,
  input  logic [7:0]        csr_wdata_i,
  output logic [7:0]        csr_status_o,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_done_i,
  input  logic              tx_empty_i
);
  logic              start_ok, frame_done, fe_s, pe_s;
  logic [DATA_W-1:0] data_s;
  logic              fast, filt, hold_v, ovr_pend;
  logic [CW-1:0]     fifo_cnt;
  rx_entry_t         head;

  urx_sampler #(.OS_NORMAL(OS_NORMAL), .OS_FAST(OS_FAST)) u_smp (
    .clk, .rst_n,
    .tick_i(os_tick_i), .rxd_i, .fast_i(fast), .nine_i(nine_bit_i),
    .par_en_i, .par_odd_i,
    .start_ok_o(start_ok), .done_o(frame_done), .data_o(data_s),
    .fe_o(fe_s), .pe_o(pe_s)
  );

  urx_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk, .rst_n,
    .start_ok_i(start_ok), .done_i(frame_done), .data_i(data_s),
    .fe_i(fe_s), .pe_i(pe_s), .filt_i(filt), .nine_i(nine_bit_i),
    .pop_i(rx_pop_i), .head_o(head), .cnt_o(fifo_cnt),
    .hold_v_o(hold_v), .ovr_pend_o(ovr_pend)
  );

  urx_csr u_csr (
    .clk, .rst_n,
    .wr_i(csr_wr_i), .wdata_i(csr_wdata_i), .tx_done_i, .tx_empty_i,
    .nonempty_i(fifo_cnt != '0), .fe_i(head.fe), .ovr_i(head.ovr),
    .pe_i(head.pe), .status_o(csr_status_o), .fast_o(fast), .filt_o(filt)
  );

  assign rx_data_o = head.data;
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    status,
  input logic          pop,
  input logic          wr,
  input logic [CW-1:0] fifo_cnt,
  input logic          hold_v,
  input logic          frame_done,
  input logic          ovr_pend
);
  // R2: head flags read zero while the buffer is empty
  a_r2_flags_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> status[4:2] == 3'b000);

  // R8: buffer never exceeds its depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R8: a pop with nothing waiting shrinks the buffer by one
  a_r8_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    pop && fifo_cnt != '0 && !hold_v |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

  // R7: a character completes only after the hold stage has drained or been dropped
  a_r7_hold_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !hold_v);

  // R7: lost-data is raised only with the buffer full and a character waiting
  a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_pend) |-> $past(hold_v) && $past(fifo_cnt) == CW'(DEPTH));

  // R10: control bits hold their value without a write
  a_r10_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(status[1:0]));
endmodule

bind serial_rx_core urx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(csr_status_o), .pop(rx_pop_i),
  .wr(csr_wr_i), .fifo_cnt(fifo_cnt), .hold_v(hold_v),
  .frame_done(frame_done), .ovr_pend(ovr_pend)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       nine_bit_i = 1'b0;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       csr_wr_i = 1'b0;
  logic [7:0] csr_wdata_i = 8'h00;
  logic [7:0] csr_status_o;
  logic       rx_pop_i = 1'b0;
  logic [8:0] rx_data_o;
  logic       tx_done_i = 1'b0;
  logic       tx_empty_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [11:0] q_m[$];   // {data[8:0], fe, ovr, pe}
  logic [11:0] hold_m;
  bit hold_vm = 0, pend_m = 0;
  bit txc_m = 0, txe_m = 1, fast_m = 0, filt_m = 0;

  serial_rx_core dut (.*);

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      os_tick_i = ~os_tick_i;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [11:0] h;
    h = (q_m.size() != 0) ? q_m[0] : 12'h000;
    return {q_m.size() != 0, txc_m, txe_m, h[2], h[1], h[0], fast_m, filt_m};
  endfunction

  task automatic check_state(input string req);
    chk(req, 32'(csr_status_o), 32'(exp_status()));
    if (q_m.size() != 0) chk(req, 32'(rx_data_o), 32'(q_m[0][11:3]));
  endtask

  task automatic model_move();
    if (hold_vm && q_m.size() < 2) begin
      q_m.push_back(hold_m);
      hold_vm = 0;
    end
  endtask

  task automatic hold_bit(input logic v);
    rxd_i = v;
    repeat ((fast_m ? 8 : 16) * 2) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit flip_par, input bit stop_v);
    int nb;
    logic p;
    bit keep;
    nb = nine_bit_i ? 9 : 8;
    if (hold_vm && q_m.size() == 2) begin
      hold_vm = 0;
      pend_m = 1;
    end
    hold_bit(1'b0);
    p = par_odd_i;
    for (int i = 0; i < nb; i++) begin
      hold_bit(d[i]);
      p = p ^ d[i];
    end
    if (par_en_i) hold_bit(p ^ flip_par);
    hold_bit(stop_v);
    rxd_i = 1'b1;
    keep = !(filt_m && !(nine_bit_i && d[8]));
    if (keep) begin
      hold_m = {(nine_bit_i ? d : {1'b0, d[7:0]}), !stop_v, pend_m, par_en_i && flip_par};
      hold_vm = 1;
      pend_m = 0;
      model_move();
    end
  endtask

  task automatic pop();
    @(negedge clk);
    rx_pop_i = 1'b1;
    @(negedge clk);
    rx_pop_i = 1'b0;
    if (q_m.size() != 0) void'(q_m.pop_front());
    model_move();
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk);
    csr_wr_i = 1'b1;
    csr_wdata_i = v;
    @(negedge clk);
    csr_wr_i = 1'b0;
    if (v[6]) txc_m = 0;
    fast_m = v[1];
    filt_m = v[0];
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", 32'(csr_status_o), 32'h20);
    chk("R1 reset data", 32'(rx_data_o), 32'h0);

    // R3 R4: normal speed, 8 bits, no parity
    send(9'h0A5, 0, 1); settle();
    check_state("R3 plain frame x16");
    pop(); settle();
    check_state("R8 empty after pop");

    // R12: short low glitch
    rxd_i = 1'b0; repeat (6) @(negedge clk); rxd_i = 1'b1;
    repeat (80) @(negedge clk);
    check_state("R12 glitch ignored");
    send(9'h05A, 0, 1); settle();
    check_state("R12 frame after glitch");
    pop();

    // R4: fast mode
    csr_write(8'h02); settle();
    check_state("R10 fast bit written");
    send(9'h03C, 0, 1); settle();
    check_state("R4 frame x8");
    pop();
    send(9'h0C3, 0, 1); settle();
    check_state("R4 second frame x8");
    pop();

    // R5: bad stop bit
    send(9'h081, 0, 0); repeat (40) @(negedge clk);
    check_state("R5 stop error set");
    pop(); settle();
    send(9'h07E, 0, 1); settle();
    check_state("R5 good stop clear");
    pop();

    // R6: parity, even and odd
    par_en_i = 1'b1;
    send(9'h013, 1, 1); settle();
    check_state("R6 even parity error");
    pop();
    send(9'h013, 0, 1); settle();
    check_state("R6 even parity good");
    pop();
    par_odd_i = 1'b1;
    send(9'h0F0, 1, 1); settle();
    check_state("R6 odd parity error");
    pop();
    send(9'h0F1, 0, 1); settle();
    check_state("R6 odd parity good");
    pop();
    par_en_i = 1'b0; par_odd_i = 1'b0;

    // R7: four back-to-back characters overrun the buffer
    csr_write(8'h00);
    send(9'h011, 0, 1);
    send(9'h022, 0, 1);
    send(9'h033, 0, 1);
    send(9'h044, 0, 1); settle();
    check_state("R7 head first char");
    pop(); settle();
    check_state("R7 second char");
    pop(); settle();
    check_state("R7 lost-data on next char");
    pop(); settle();
    check_state("R7 drained");

    // R9: address filter with 9-bit frames
    nine_bit_i = 1'b1;
    csr_write(8'h03);
    send(9'h055, 0, 1); settle();
    check_state("R9 data frame dropped");
    send(9'h1A7, 0, 1); settle();
    check_state("R9 address frame kept");
    pop();
    csr_write(8'h02);
    send(9'h066, 0, 1); settle();
    check_state("R9 filter off keeps data");
    pop();
    nine_bit_i = 1'b0;

    // R10 R11: register bits
    @(negedge clk); tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
    txc_m = 1; @(negedge clk);
    check_state("R11 done sets bit6");
    csr_write(8'hBC); @(negedge clk);
    check_state("R10 read-only bits ignore write");
    @(negedge clk); csr_wr_i = 1'b1; csr_wdata_i = 8'h40; tx_done_i = 1'b1;
    @(negedge clk); csr_wr_i = 1'b0; tx_done_i = 1'b0;
    fast_m = 0; filt_m = 0;
    check_state("R11 set wins over clear");
    csr_write(8'h40); @(negedge clk);
    check_state("R10 write one clears bit6");
    tx_empty_i = 1'b0; txe_m = 0; repeat (2) @(negedge clk);
    check_state("R11 empty bit follows input");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule